// File: doc/BRIEF.md
# Stereo Digital Volume Ramp Controller

This block attenuates and mutes a stereo stream of signed PCM samples, one gain setting per channel. Left is channel A and right is channel B. Each channel takes an 8-bit setting: a mute flag and a 7-bit attenuation code in 1 dB steps. The block moves the attenuation it actually applies toward that setting without audible clicks. A shared 2-bit mode chooses how a change takes effect. It can take effect at once or at the next zero crossing of the signal. It can also step 1 dB per sample, or step 1 dB only at zero crossings. A link option makes channel B use channel A's setting.

Samples arrive with a one-cycle valid strobe. Gain is formed as a 1 dB mantissa from a six-entry table followed by an arithmetic right shift of one bit per 6 dB. The result is rounded and saturated. Mute is a transition to full attenuation, after which the output is exactly zero. A wait for a zero crossing is bounded: after a fixed number of sample periods with no crossing, the pending change is forced.

Top module: `stereo_vol_ramp`

## Requirements
- R1: A strobe on `in_valid` at a clock edge raises `out_valid` for exactly the following cycle, and `out_l`/`out_r` change at that same edge. Without a strobe, `out_valid` is low and the outputs and the applied attenuation hold.
- R2: For an applied attenuation a below the full-attenuation value, write a = 6q + r with r in 0..5. The output is (x*M[r] + 2^(14+q)) >>> (15+q), saturated to the signed 24-bit range, where M = {32768, 29205, 26029, 23198, 20675, 18427}.
- R3: Bit 7 of a channel setting is mute and bits 6..0 are the attenuation code in dB. Codes of 96 and above are full attenuation, and full attenuation gives an output of exactly zero. After reset, both applied attenuations are 0 dB and the outputs are zero.
- R4: With mode 00 (direct), the applied attenuation equals the channel target on every strobe.
- R5: With mode 01 (zero cross), a pending target is applied on a strobe whose sample is zero or whose sign bit differs from the previous strobe's sample. The sign before the first strobe after reset counts as non-negative.
- R6: With mode 10 (ramp), each strobe moves the applied attenuation by 1 dB toward the target until the two are equal.
- R7: With mode 11 (ramp at crossings), each strobe that is a zero crossing, as defined in R5, moves the applied attenuation by 1 dB toward the target.
- R8: In modes 01 and 11, the 512th consecutive strobe with a change pending and no crossing applies the change (the full target in 01, one step in 11). The count restarts after any applied change, and whenever nothing is pending.
- R9: The mute flag makes the target full attenuation. The transition follows the selected mode, and the output is zero once full attenuation is reached.
- R10: With `link_b_to_a` high, channel B uses channel A's setting (mute and code), and its `vol_b` input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe, one cycle per stereo sample |
| in_l | input | 24 | Left (channel A) sample, two's complement |
| in_r | input | 24 | Right (channel B) sample, two's complement |
| vol_a | input | 8 | Channel A setting: bit 7 mute, bits 6..0 attenuation dB |
| vol_b | input | 8 | Channel B setting, same layout |
| xfer_mode | input | 2 | 00 direct, 01 zero cross, 10 ramp, 11 ramp at crossings |
| link_b_to_a | input | 1 | Channel B follows channel A's setting |
| out_valid | output | 1 | Output sample strobe |
| out_l | output | 24 | Scaled left sample |
| out_r | output | 24 | Scaled right sample |

## Verification
A wrong applied attenuation shows at the ports on the very next strobe, because every output sample is the input scaled by the current attenuation. A one-step error in a ramp is therefore visible as a wrong amplitude one cycle after the strobe. A wrong stored sign or a wrong crossing-wait count shows later. It appears only when the model expects a change to be applied or held, which can be as late as 512 strobes after the target moved. For that reason the timeout run uses a long stretch of same-sign samples. A mute path that stops short of full attenuation shows as a non-zero output where exact zero is due.

// File: rtl/svr_pkg.sv
package svr_pkg;

    typedef enum logic [1:0] {
        XM_DIRECT  = 2'b00,
        XM_ZCROSS  = 2'b01,
        XM_RAMP    = 2'b10,
        XM_RAMP_ZC = 2'b11
    } xfer_mode_e;

endpackage

// File: rtl/svr_scaler.sv
module svr_scaler #(
    parameter int SAMPLE_W = 24,
    parameter int ATT_W    = 7,
    parameter int FULL_ATT = 96
) (
    input  logic signed [SAMPLE_W-1:0] x,
    input  logic        [ATT_W-1:0]    att,
    output logic signed [SAMPLE_W-1:0] y
);
    localparam int FRAC_W = 15;
    localparam int MANT_W = FRAC_W + 2;
    localparam int PW     = SAMPLE_W + MANT_W + 2;
    localparam logic [ATT_W-1:0] FULL_CODE = ATT_W'(FULL_ATT);
    localparam logic signed [PW-1:0] SAT_MAX = {{(PW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [PW-1:0] SAT_MIN = {{(PW-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

    logic        [ATT_W-1:0]  oct;
    logic        [ATT_W-1:0]  frac;
    logic        [MANT_W-1:0] mant;
    logic signed [PW-1:0]     xe;
    logic signed [PW-1:0]     me;
    logic signed [PW-1:0]     prod;
    logic signed [PW-1:0]     bias;
    logic signed [PW-1:0]     rnd;
    int                       sh;

    always_comb begin
        oct  = att / ATT_W'(6);
        frac = att % ATT_W'(6);
        case (frac)
            ATT_W'(0): mant = MANT_W'(32768);
            ATT_W'(1): mant = MANT_W'(29205);
            ATT_W'(2): mant = MANT_W'(26029);
            ATT_W'(3): mant = MANT_W'(23198);
            ATT_W'(4): mant = MANT_W'(20675);
            default:   mant = MANT_W'(18427);
        endcase
        xe   = {{(PW-SAMPLE_W){x[SAMPLE_W-1]}}, x};
        me   = {{(PW-MANT_W){1'b0}}, mant};
        prod = xe * me;
        sh   = int'(oct) + FRAC_W;
        bias = PW'(1) <<< (sh - 1);
        rnd  = (prod + bias) >>> sh;
        if (att >= FULL_CODE) begin
            y = '0;
        end else if (rnd > SAT_MAX) begin
            y = SAT_MAX[SAMPLE_W-1:0];
        end else if (rnd < SAT_MIN) begin
            y = SAT_MIN[SAMPLE_W-1:0];
        end else begin
            y = rnd[SAMPLE_W-1:0];
        end
    end
endmodule

// File: rtl/svr_channel.sv
module svr_channel
    import svr_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int ATT_W      = 7,
    parameter int FULL_ATT   = 96,
    parameter int ZC_TIMEOUT = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strobe,
    input  logic signed [SAMPLE_W-1:0] x,
    input  logic        [ATT_W-1:0]    tgt,
    input  xfer_mode_e                 mode,
    output logic signed [SAMPLE_W-1:0] y,
    output logic        [ATT_W-1:0]    att
);
    localparam int CNT_W = $clog2(ZC_TIMEOUT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ZC_TIMEOUT - 1);

    typedef struct packed {
        logic [ATT_W-1:0]           att;
        logic                       neg;
        logic [CNT_W-1:0]           wait_cnt;
        logic signed [SAMPLE_W-1:0] y;
    } ch_state_t;

    ch_state_t s_d, s_q;

    logic                       zc;
    logic                       pending;
    logic                       go;
    logic                       wait_mode;
    logic [ATT_W-1:0]           stepped;
    logic [ATT_W-1:0]           att_next;
    logic signed [SAMPLE_W-1:0] scaled;

    always_comb begin
        zc        = (x == '0) || (x[SAMPLE_W-1] != s_q.neg);
        pending   = (s_q.att != tgt);
        go        = zc || (s_q.wait_cnt == CNT_LAST);
        wait_mode = (mode == XM_ZCROSS) || (mode == XM_RAMP_ZC);
        if (s_q.att < tgt) begin
            stepped = s_q.att + 1'b1;
        end else if (s_q.att > tgt) begin
            stepped = s_q.att - 1'b1;
        end else begin
            stepped = s_q.att;
        end
        case (mode)
            XM_DIRECT: att_next = tgt;
            XM_ZCROSS: att_next = go ? tgt : s_q.att;
            XM_RAMP:   att_next = stepped;
            default:   att_next = go ? stepped : s_q.att;
        endcase
    end

    svr_scaler #(
        .SAMPLE_W(SAMPLE_W),
        .ATT_W   (ATT_W),
        .FULL_ATT(FULL_ATT)
    ) u_scale (
        .x  (x),
        .att(att_next),
        .y  (scaled)
    );

    always_comb begin
        s_d = s_q;
        if (strobe) begin
            s_d.att = att_next;
            s_d.neg = x[SAMPLE_W-1];
            s_d.y   = scaled;
            if (!wait_mode || !pending || go) begin
                s_d.wait_cnt = '0;
            end else begin
                s_d.wait_cnt = s_q.wait_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign y   = s_q.y;
    assign att = s_q.att;
endmodule

// File: rtl/stereo_vol_ramp.sv
module stereo_vol_ramp
    import svr_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int ATT_W      = 7,
    parameter int FULL_ATT   = 96,
    parameter int ZC_TIMEOUT = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_l,
    input  logic signed [SAMPLE_W-1:0] in_r,
    input  logic        [ATT_W:0]      vol_a,
    input  logic        [ATT_W:0]      vol_b,
    input  logic        [1:0]          xfer_mode,
    input  logic                       link_b_to_a,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_l,
    output logic signed [SAMPLE_W-1:0] out_r
);
    localparam int NCH = 2;
    localparam logic [ATT_W-1:0] FULL_CODE = ATT_W'(FULL_ATT);

    typedef struct packed {
        logic valid;
    } top_state_t;

    top_state_t top_d, top_q;

    logic signed [SAMPLE_W-1:0] ch_in  [NCH];
    logic signed [SAMPLE_W-1:0] ch_out [NCH];
    logic        [ATT_W-1:0]    ch_att [NCH];
    logic        [ATT_W-1:0]    att_l;
    logic        [ATT_W-1:0]    att_r;
    xfer_mode_e                 mode_e;

    assign mode_e   = xfer_mode_e'(xfer_mode);
    assign ch_in[0] = in_l;
    assign ch_in[1] = in_r;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [ATT_W:0]   setting;
        logic [ATT_W-1:0] tgt;

        always_comb begin
            setting = ((c != 0) && !link_b_to_a) ? vol_b : vol_a;
            if (setting[ATT_W] || (setting[ATT_W-1:0] > FULL_CODE)) begin
                tgt = FULL_CODE;
            end else begin
                tgt = setting[ATT_W-1:0];
            end
        end

        svr_channel #(
            .SAMPLE_W  (SAMPLE_W),
            .ATT_W     (ATT_W),
            .FULL_ATT  (FULL_ATT),
            .ZC_TIMEOUT(ZC_TIMEOUT)
        ) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .strobe(in_valid),
            .x     (ch_in[c]),
            .tgt   (tgt),
            .mode  (mode_e),
            .y     (ch_out[c]),
            .att   (ch_att[c])
        );
    end

    always_comb begin
        top_d       = top_q;
        top_d.valid = in_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign out_valid = top_q.valid;
    assign out_l     = ch_out[0];
    assign out_r     = ch_out[1];
    assign att_l     = ch_att[0];
    assign att_r     = ch_att[1];
endmodule

// File: rtl/svr_checker.sv
module svr_checker #(
    parameter int SAMPLE_W = 24,
    parameter int ATT_W    = 7,
    parameter int FULL_ATT = 96
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic [1:0]                 xfer_mode,
    input logic                       link_b_to_a,
    input logic                       out_valid,
    input logic signed [SAMPLE_W-1:0] out_l,
    input logic signed [SAMPLE_W-1:0] out_r,
    input logic [ATT_W-1:0]           att_l,
    input logic [ATT_W-1:0]           att_r
);
    localparam logic [ATT_W-1:0] FULL_CODE = ATT_W'(FULL_ATT);

    AST_VALID_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_l) && $stable(out_r) && $stable(att_l) && $stable(att_r))); // R1
    AST_ATT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (att_l <= FULL_CODE) && (att_r <= FULL_CODE)); // R3
    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xfer_mode == 2'b10) |=>
        ((att_l == $past(att_l)) || (att_l == $past(att_l) + 1'b1) || ($past(att_l) == att_l + 1'b1))); // R6
    AST_FULL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && att_l == FULL_CODE) |-> (out_l == '0)); // R9
    AST_LINK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (link_b_to_a && in_valid && xfer_mode == 2'b00) |=> (att_r == att_l)); // R10
endmodule

bind stereo_vol_ramp svr_checker #(
    .SAMPLE_W(SAMPLE_W),
    .ATT_W   (ATT_W),
    .FULL_ATT(FULL_ATT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .xfer_mode  (xfer_mode),
    .link_b_to_a(link_b_to_a),
    .out_valid  (out_valid),
    .out_l      (out_l),
    .out_r      (out_r),
    .att_l      (att_l),
    .att_r      (att_r)
);

// File: tb/sim_stereo_vol_ramp.sv
module sim_stereo_vol_ramp;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [23:0] in_l = '0;
    logic signed [23:0] in_r = '0;
    logic [7:0] vol_a = '0;
    logic [7:0] vol_b = '0;
    logic [1:0] xfer_mode = 2'b00;
    logic link_b_to_a = 1'b0;
    logic out_valid;
    logic signed [23:0] out_l;
    logic signed [23:0] out_r;

    int checks = 0;
    int failures = 0;
    string cur_req = "R3";
    bit running = 1'b0;

    int m_att [2];
    bit m_neg [2];
    int m_cnt [2];
    int m_out [2];
    bit m_valid;

    always #2 clk = ~clk;

    stereo_vol_ramp u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
        .vol_a(vol_a), .vol_b(vol_b), .xfer_mode(xfer_mode), .link_b_to_a(link_b_to_a),
        .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
    );

    function automatic int scale(int x, int a);
        longint mt [6] = '{32768, 29205, 26029, 23198, 20675, 18427};
        longint p;
        longint res;
        int sh;
        if (a >= 96) return 0;
        sh  = 15 + a / 6;
        p   = longint'(x) * mt[a % 6];
        res = (p + (64'sd1 <<< (sh - 1))) >>> sh;
        if (res > 8388607) res = 8388607;
        if (res < -8388608) res = -8388608;
        return int'(res);
    endfunction

    function automatic int target_of(logic [7:0] v);
        if (v[7]) return 96;
        if (int'(v[6:0]) > 96) return 96;
        return int'(v[6:0]);
    endfunction

    function automatic int toward(int a, int t);
        if (a < t) return a + 1;
        if (a > t) return a - 1;
        return a;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_att[c] = 0; m_neg[c] = 0; m_cnt[c] = 0; m_out[c] = 0;
            end
            m_valid = 0;
        end else begin
            m_valid = in_valid;
            if (in_valid) begin
                for (int c = 0; c < 2; c++) begin
                    int x;
                    int t;
                    bit zc;
                    bit go;
                    x  = (c == 0) ? int'(in_l) : int'(in_r);
                    t  = target_of((c == 0 || link_b_to_a) ? vol_a : vol_b);
                    zc = (x == 0) || ((x < 0) != m_neg[c]);
                    go = 0;
                    if (xfer_mode == 2'b01 || xfer_mode == 2'b11) begin
                        if (m_att[c] != t) begin
                            if (zc || m_cnt[c] == 511) begin
                                go = 1; m_cnt[c] = 0;
                            end else begin
                                m_cnt[c]++;
                            end
                        end else begin
                            m_cnt[c] = 0;
                        end
                    end else begin
                        m_cnt[c] = 0;
                    end
                    case (xfer_mode)
                        2'b00: m_att[c] = t;
                        2'b01: if (go) m_att[c] = t;
                        2'b10: m_att[c] = toward(m_att[c], t);
                        default: if (go) m_att[c] = toward(m_att[c], t);
                    endcase
                    m_neg[c] = (x < 0);
                    m_out[c] = scale(x, m_att[c]);
                end
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running && rst_n) begin
            check({cur_req, " R1 valid"}, int'(out_valid), int'(m_valid));
            check({cur_req, " left"}, int'(out_l), m_out[0]);
            check({cur_req, " right"}, int'(out_r), m_out[1]);
        end
    end

    task automatic strobe(int l, int r);
        @(negedge clk);
        in_valid = 1'b1; in_l = 24'(l); in_r = 24'(r);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 reset left", int'(out_l), 0);
        check("R3 reset valid", int'(out_valid), 0);
        running = 1'b1;

        cur_req = "R3";
        strobe(1000, -8388608); idle(1);
        check("R3 0 dB passthrough", int'(out_r), -8388608);
        strobe(8388607, -1); strobe(-5, 7); idle(2);
        vol_a = 8'd100; strobe(12345, 777); idle(1);
        check("R3 code above range is silent", int'(out_l), 0);

        cur_req = "R4";
        vol_a = 8'd6; vol_b = 8'd12; strobe(1000, 1000); idle(1);
        check("R4 direct 6 dB", int'(out_l), 500);
        check("R2 12 dB", int'(out_r), 250);
        vol_a = 8'd47; vol_b = 8'd95; strobe(-777777, 8000000); idle(1);

        cur_req = "R5";
        vol_a = 8'd0; vol_b = 8'd0; strobe(100, 100); idle(1);
        xfer_mode = 2'b01; vol_a = 8'd20; vol_b = 8'd3;
        for (int i = 0; i < 5; i++) strobe(3000 + i, 4000);
        idle(1);
        check("R5 held before crossing", int'(out_l), 3004);
        strobe(-3000, 0); strobe(-2000, 50); idle(1);

        cur_req = "R6";
        xfer_mode = 2'b00; vol_a = 8'd0; vol_b = 8'd0; strobe(1, 1); idle(1);
        xfer_mode = 2'b10; vol_a = 8'd20; vol_b = 8'd5;
        strobe(1000, 1000); idle(1);
        check("R6 first ramp step", int'(out_l), 891);
        for (int i = 0; i < 25; i++) strobe(-4000000 + i * 9000, 2222222);
        idle(2);
        vol_a = 8'd2; for (int i = 0; i < 20; i++) strobe(654321, -654321);
        idle(1);

        cur_req = "R7";
        xfer_mode = 2'b11; vol_a = 8'd10; vol_b = 8'd0;
        for (int i = 0; i < 30; i++) strobe((i % 3 == 0) ? -5000 : 5000, 100 - i * 7);
        idle(1);

        cur_req = "R8";
        xfer_mode = 2'b00; vol_a = 8'd0; vol_b = 8'd0; strobe(10, 10); idle(1);
        xfer_mode = 2'b01; vol_a = 8'd30; vol_b = 8'd30;
        for (int i = 0; i < 511; i++) strobe(6000000, 6000000);
        idle(1);
        check("R8 still waiting at 511", int'(out_l), 6000000);
        strobe(6000000, 6000000); idle(1);
        check("R8 forced at 512", int'(out_l), scale(6000000, 30));
        xfer_mode = 2'b11; vol_a = 8'd34;
        for (int i = 0; i < 1030; i++) strobe(5000, 5000);
        idle(1);

        cur_req = "R9";
        xfer_mode = 2'b10; vol_a = 8'h80 | 8'd5; vol_b = 8'd0;
        for (int i = 0; i < 70; i++) strobe(8000000, -8000000);
        idle(1);
        check("R9 mute reaches zero", int'(out_l), 0);
        xfer_mode = 2'b00; vol_a = 8'd0; strobe(-9, 9); idle(1);

        cur_req = "R10";
        link_b_to_a = 1'b1; vol_a = 8'd18; vol_b = 8'd0; strobe(4096, 4096); idle(1);
        check("R10 B follows A", int'(out_r), scale(4096, 18));
        vol_b = 8'h80; strobe(4096, -4096); idle(1);
        check("R10 vol_b ignored", int'(out_r), scale(-4096, 18));
        link_b_to_a = 1'b0; strobe(4096, -4096); idle(2);
        check("R9 B muted once unlinked", int'(out_r), 0);

        running = 1'b0;
        finish_run();
    end
endmodule